// File: doc/BRIEF.md
# One-Position Shift and Rotate Unit

This block takes a data word and either hands it on untouched or moves every bit one place, as chosen by a two-bit operation code. Four moves are offered: no move, a move toward the most significant end that brings a 1 in at the bottom, a move toward the least significant end that brings a 0 in at the top, and a rotation toward the least significant end where the bit that falls off the bottom wraps round to the top.

The unit is purely combinational and holds no state. Each result bit is picked by its own four-way selector. The inputs to that selector are the bit at the same position, the neighbour on either side, or a constant fill. The word width is a parameter with a default of 8. The two fill constants are parameters too, so a datapath can reuse the same structure with other edge values.

Top module: `onestep_shrot`

## Requirements
- R1: With operation code 2'b00 the output equals the input word bit for bit.
- R2: With code 2'b01, output bit i equals input bit i-1 for every i from 1 to WIDTH-1, and the input's top bit has no effect on the output.
- R3: With code 2'b01 the output's least significant bit is 1 whatever the input.
- R4: With code 2'b10, output bit i equals input bit i+1 for every i from 0 to WIDTH-2, and the input's bottom bit has no effect on the output.
- R5: With code 2'b10 the output's most significant bit is 0 whatever the input.
- R6: With code 2'b11, output bit i equals input bit i+1 for i up to WIDTH-2, and the output's top bit equals the input's bottom bit.
- R7: The output follows any change of code or data with no clock edge in between.
- R8: For 8-bit words: 8'b10110100 gives 8'b01101001 under code 01, 8'b01011010 under code 10 and 8'b01011010 under code 11; 8'b10110101 gives 8'b11011010 under code 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel | input | 2 | Operation code: 00 none, 01 up with 1 fill, 10 down with 0 fill, 11 rotate down |
| din | input | WIDTH | Word to be moved |
| dout | output | WIDTH | Moved word |

## Verification
Every one of the 256 byte values is applied under all four codes. That sweep tells apart a fill bit taken from the wrong constant, a neighbour taken from the wrong side, and a rotate that fails to wrap. All-zero and all-one words are applied on their own. All-zero exposes a fill of 1 where a 0 belongs, and all-one exposes the reverse. A lone one walked across each position shows which input bit reaches which output bit. It also shows that the bit pushed off the end is really gone. The fixed example words check a few known results. Changing the code while the data stays still, and the data while the code stays still, shows that the output follows each at once.

// File: rtl/onestep_pkg.sv
package onestep_pkg;

    typedef enum logic [1:0] {
        OP_KEEP     = 2'b00,
        OP_UP_FILL1 = 2'b01,
        OP_DN_FILL0 = 2'b10,
        OP_ROT_DN   = 2'b11
    } op_e;

    localparam int unsigned OP_COUNT = 4;

    function automatic op_e decode_op(input logic [1:0] code);
        return op_e'(code);
    endfunction

endpackage

// File: rtl/shrot_taps.sv
module shrot_taps #(
    parameter int unsigned WIDTH      = 8,
    parameter logic        FILL_UP    = 1'b1,
    parameter logic        FILL_DOWN  = 1'b0
) (
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] tap_keep,
    output logic [WIDTH-1:0] tap_up,
    output logic [WIDTH-1:0] tap_dn,
    output logic [WIDTH-1:0] tap_rot
);

    localparam int unsigned TOP = WIDTH - 1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_tap
        assign tap_keep[i] = din[i];

        if (i == 0) begin : g_low
            assign tap_up[i] = FILL_UP;
        end else begin : g_up
            assign tap_up[i] = din[i-1];
        end

        if (i == TOP) begin : g_high
            assign tap_dn[i]  = FILL_DOWN;
            assign tap_rot[i] = din[0];
        end else begin : g_dn
            assign tap_dn[i]  = din[i+1];
            assign tap_rot[i] = din[i+1];
        end
    end

endmodule

// File: rtl/shrot_bitmux.sv
module shrot_bitmux
    import onestep_pkg::*;
(
    input  logic [1:0]          code,
    input  logic [OP_COUNT-1:0] d,
    output logic                y
);

    op_e op;

    always_comb begin
        op = decode_op(code);
        unique case (op)
            OP_KEEP:     y = d[0];
            OP_UP_FILL1: y = d[1];
            OP_DN_FILL0: y = d[2];
            OP_ROT_DN:   y = d[3];
        endcase
    end

endmodule

// File: rtl/onestep_shrot.sv
module onestep_shrot
    import onestep_pkg::*;
#(
    parameter int unsigned WIDTH     = 8,
    parameter logic        FILL_UP   = 1'b1,
    parameter logic        FILL_DOWN = 1'b0
) (
    input  logic [1:0]       sel,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] tap_keep;
    logic [WIDTH-1:0] tap_up;
    logic [WIDTH-1:0] tap_dn;
    logic [WIDTH-1:0] tap_rot;

    shrot_taps #(
        .WIDTH     (WIDTH),
        .FILL_UP   (FILL_UP),
        .FILL_DOWN (FILL_DOWN)
    ) u_taps (
        .din      (din),
        .tap_keep (tap_keep),
        .tap_up   (tap_up),
        .tap_dn   (tap_dn),
        .tap_rot  (tap_rot)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        logic [OP_COUNT-1:0] slice_in;
        assign slice_in = {tap_rot[i], tap_dn[i], tap_up[i], tap_keep[i]};

        shrot_bitmux u_mux (
            .code (sel),
            .d    (slice_in),
            .y    (dout[i])
        );
    end

endmodule

// File: rtl/onestep_shrot_chk.sv
module onestep_shrot_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic [1:0]       sel,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] dout
);

    always_comb begin
        if (sel == 2'b00) begin
            // R1
            keep_equal_chk: assert (dout == din);
        end
        if (sel == 2'b01) begin
            // R2
            up_body_chk: assert ((dout >> 1) == (din & {1'b0, {(WIDTH-1){1'b1}}}));
            // R3
            up_fill_chk: assert (dout[0] == 1'b1);
        end
        if (sel == 2'b10) begin
            // R4
            dn_body_chk: assert ((dout << 1) == (din & {{(WIDTH-1){1'b1}}, 1'b0}));
            // R5
            dn_fill_chk: assert (dout[WIDTH-1] == 1'b0);
        end
        if (sel == 2'b11) begin
            // R6
            rot_wrap_chk: assert ((dout[WIDTH-1] == din[0]) && ($countones(dout) == $countones(din)));
        end
    end

endmodule

bind onestep_shrot onestep_shrot_chk #(.WIDTH(WIDTH)) u_chk (
    .sel  (sel),
    .din  (din),
    .dout (dout)
);

// File: tb/onestep_shrot_bench.sv
module onestep_shrot_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   sel = 2'b00;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    onestep_shrot u_onestep_shrot (
        .sel  (sel),
        .din  (din),
        .dout (dout)
    );

    always #5 clk = ~clk;

    always_ff @(posedge clk) begin
        if (rst) cycles <= 0;
        else     cycles <= cycles + 1;
    end

    function automatic logic [W-1:0] model(input logic [1:0] s, input logic [W-1:0] v);
        case (s)
            2'b00:   return v;
            2'b01:   return {v[W-2:0], 1'b1};
            2'b10:   return {1'b0, v[W-1:1]};
            default: return {v[0], v[W-1:1]};
        endcase
    endfunction

    task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s sel=%b din=%b got=%b expected=%b", req, sel, din, got, exp);
        end
    endtask

    task automatic drive(input logic [1:0] s, input logic [W-1:0] v);
        @(negedge clk);
        sel = s;
        din = v;
        #1;
    endtask

    task automatic t_idle;
        #1;
        chk("R1 initial", dout, 8'h00);
    endtask

    task automatic t_keep;
        drive(2'b00, 8'hA5); chk("R1", dout, 8'hA5);
        drive(2'b00, 8'hFF); chk("R1", dout, 8'hFF);
    endtask

    task automatic t_up;
        drive(2'b01, 8'h00); chk("R3", dout, 8'h01);
        drive(2'b01, 8'hFF); chk("R2", dout, 8'hFF);
        drive(2'b01, 8'h80); chk("R2 top bit dropped", dout, 8'h01);
        for (int i = 0; i < W-1; i++) begin
            drive(2'b01, 8'(1 << i)); chk("R2 walk", dout, 8'((1 << (i+1)) | 1));
        end
    endtask

    task automatic t_dn;
        drive(2'b10, 8'hFF); chk("R5", dout, 8'h7F);
        drive(2'b10, 8'h01); chk("R4 bottom bit dropped", dout, 8'h00);
        for (int i = 1; i < W; i++) begin
            drive(2'b10, 8'(1 << i)); chk("R4 walk", dout, 8'(1 << (i-1)));
        end
    endtask

    task automatic t_rot;
        drive(2'b11, 8'h01); chk("R6 wrap", dout, 8'h80);
        drive(2'b11, 8'hFF); chk("R6", dout, 8'hFF);
        drive(2'b11, 8'h00); chk("R6", dout, 8'h00);
    endtask

    task automatic t_examples;
        drive(2'b01, 8'b10110100); chk("R8 up", dout, 8'b01101001);
        drive(2'b10, 8'b10110100); chk("R8 down", dout, 8'b01011010);
        drive(2'b11, 8'b10110100); chk("R8 rot", dout, 8'b01011010);
        drive(2'b11, 8'b10110101); chk("R8 rot", dout, 8'b11011010);
    endtask

    task automatic t_live;
        @(negedge clk);
        sel = 2'b00; din = 8'h3C; #1;
        chk("R7 keep", dout, 8'h3C);
        sel = 2'b01; #1;
        chk("R7 code change", dout, 8'h79);
        din = 8'hC3; #1;
        chk("R7 data change", dout, 8'h87);
    endtask

    task automatic t_sweep;
        for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < 256; v++) begin
                drive(2'(s), 8'(v));
                chk("R1 R2 R3 R4 R5 R6 sweep", dout, model(2'(s), 8'(v)));
            end
        end
    endtask

    initial begin
        t_idle();
        repeat (2) @(posedge clk);
        rst = 1'b0;
        t_keep();
        t_up();
        t_dn();
        t_rot();
        t_examples();
        t_live();
        t_sweep();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait (cycles > 100000 || done);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired got=%0d cycles expected=completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule